// File: doc/BRIEF.md
# Interrupt Status and Enable Register Bank

This block collects four event lines from a FIFO-based peripheral and turns them into one interrupt request. A rising edge on an event line latches a per-source status bit. A per-source enable mask selects which status bits may raise the request. A single global enable bit then gates the combined request onto the output.

Software reaches three 32-bit registers through a simple strobe interface. It writes the global enable bit. It flips status bits by writing ones to them, which both acknowledges and, when needed, raises sources. It loads the enable mask directly. Read data comes back one clock after the read strobe.

Top module: `irq_bank_top`

## Requirements
- R1: After a synchronous active-high reset, the status, enable and global enable registers are zero, `irq` is low, and `rd_data` is zero.
- R2: Word offset 0 holds the global enable in bit 31. A write loads that bit from `wr_data[31]`, and a read returns it in bit 31 with every other bit zero.
- R3: While the global enable is 0, `irq` stays low whatever the status and enable contents.
- R4: A status bit sets on a 0-to-1 transition of its `evt_in` line. The event edge detector starts from 0 after reset. A level held high sets the bit only once, so a bit that software flips back to 0 stays 0 while the level holds.
- R5: A write to the status register (word offset 1) flips every status bit whose `wr_data` bit is 1 and leaves bits written with 0 unchanged. A flip can take a bit from 0 to 1 as well as from 1 to 0.
- R6: A write to the enable register (word offset 2) loads the mask: a 1 enables that source and a 0 disables it. The new mask replaces the old one and is not ORed into it.
- R7: Status, enable and `evt_in` share one bit layout: bit 3 read FIFO full, bit 2 write FIFO empty, bit 1 read FIFO half full, bit 0 write FIFO half full.
- R8: Only bits 3:0 of status and enable exist. Their upper bits, and bits 30:0 of the global enable word, read as zero and ignore written values. Word offset 3 reads as zero.
- R9: `irq` is registered. In the cycle after the registers hold a given state, it equals global enable AND the OR over all sources of (status AND enable).
- R10: When an event edge and a status write with a 1 hit the same bit in one cycle, the bit ends up 1.
- R11: `rd_data` updates only on a clock edge with `rd_en` high, to the selected register's value before that edge, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word offset: 0 global enable, 1 status, 2 enable |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| evt_in | input | 4 | Event lines in the status bit layout |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a status write and an event edge landing on the same bit in the same cycle while that bit is already 1. A flip alone would clear the bit, so only the set-over-flip priority keeps it at 1. The bench first raises the bit with a flip write. It then drives the event line's rising edge and a flip write to that bit at the same falling edge, so both meet at one rising edge. It also holds an event line high across a flip write, which shows that a level cannot set a bit a second time.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int NUM_SRC  = 4;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int GLB_BIT  = 31;

    localparam int SRC_WR_HALF  = 0;
    localparam int SRC_RD_HALF  = 1;
    localparam int SRC_WR_EMPTY = 2;
    localparam int SRC_RD_FULL  = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_GLOBAL = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] widen_src(input logic [NUM_SRC-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_SRC-1:0] = v;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] widen_glb(input logic g);
        logic [DATA_W-1:0] r;
        r = '0;
        r[GLB_BIT] = g;
        return r;
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) lvl_q[i] <= 1'b0;
            else     lvl_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~lvl_q[i];
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flip_en,
    input  logic [N-1:0] flip_mask,
    input  logic [N-1:0] set_mask,
    output logic [N-1:0] status
);
    logic [N-1:0] flipped;

    always_comb begin
        flipped = status;
        if (flip_en) flipped = status ^ flip_mask;
    end

    // event set is applied after the flip so it has priority
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= flipped | set_mask;
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd,
    input  reg_sel_e           sel,
    input  logic               glb,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] enable,
    output logic [DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] sel_word;

    always_comb begin
        unique case (sel)
            SEL_GLOBAL: sel_word = widen_glb(glb);
            SEL_STATUS: sel_word = widen_src(status);
            SEL_ENABLE: sel_word = widen_src(enable);
            default:    sel_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= sel_word;
    end
endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
    import irq_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic              irq
);
    bus_req_t           req;
    logic [NUM_SRC-1:0] evt_rise;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic               glb_q;
    logic               req_any;
    logic               unused_wr_bits;

    assign req.wr   = wr_en;
    assign req.rd   = rd_en;
    assign req.sel  = reg_sel_e'(reg_addr);
    assign req.data = wr_data;

    assign unused_wr_bits = ^req.data[GLB_BIT-1:NUM_SRC];

    irq_edge_detect #(.N(NUM_SRC)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (evt_in),
        .rise (evt_rise)
    );

    irq_status_reg #(.N(NUM_SRC)) u_status (
        .clk       (clk),
        .rst       (rst),
        .flip_en   (req.wr && req.sel == SEL_STATUS),
        .flip_mask (req.data[NUM_SRC-1:0]),
        .set_mask  (evt_rise),
        .status    (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            glb_q    <= 1'b0;
        end else if (req.wr) begin
            if (req.sel == SEL_ENABLE) enable_q <= req.data[NUM_SRC-1:0];
            if (req.sel == SEL_GLOBAL) glb_q    <= req.data[GLB_BIT];
        end
    end

    assign req_any = |(status_q & enable_q);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= glb_q & req_any;
    end

    irq_read_mux u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd     (req.rd),
        .sel    (req.sel),
        .glb    (glb_q),
        .status (status_q),
        .enable (enable_q),
        .rdata  (rd_data)
    );
endmodule

// File: rtl/irq_bank_checker.sv
module irq_bank_checker
    import irq_bank_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_SRC-1:0] wr_low,
    input logic [DATA_W-1:0]  rd_data,
    input logic               irq,
    input logic [NUM_SRC-1:0] evt_rise,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic               glb_q
);
    logic sts_wr;
    logic ena_wr;
    assign sts_wr = wr_en && reg_addr == 2'd1;
    assign ena_wr = wr_en && reg_addr == 2'd2;

    a_r3_global_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !glb_q |=> !irq);

    a_r9_irq_tracks_regs: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(glb_q && (status_q & enable_q) != '0));

    a_r10_edge_sets_bit: assert property (@(posedge clk) disable iff (rst)
        evt_rise != '0 |=> (status_q & $past(evt_rise)) == $past(evt_rise));

    a_r5_status_holds: assert property (@(posedge clk) disable iff (rst)
        (!sts_wr && evt_rise == '0) |=> $stable(status_q));

    a_r6_enable_loads: assert property (@(posedge clk) disable iff (rst)
        ena_wr |=> enable_q == $past(wr_low));

    a_r8_unused_bits_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[GLB_BIT-1:NUM_SRC] == '0);

    a_r11_read_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind irq_bank_top irq_bank_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .reg_addr (reg_addr),
    .wr_low   (wr_data[3:0]),
    .rd_data  (rd_data),
    .irq      (irq),
    .evt_rise (evt_rise),
    .status_q (status_q),
    .enable_q (enable_q),
    .glb_q    (glb_q)
);

// File: tb/test_irq_bank_top.sv
module test_irq_bank_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [1:0]  reg_addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [3:0]  evt_in;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    irq_bank_top i_irq_bank_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .evt_in(evt_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        evt_in = evt_in | m;
        @(negedge clk);
        evt_in = evt_in & ~m;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 rd_data after reset", rd_data, 32'h0);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
        rd(2'd0, v); chk("R1 global enable reset", v, 32'h0);
        rd(2'd1, v); chk("R1 status reset", v, 32'h0);
        rd(2'd2, v); chk("R1 enable reset", v, 32'h0);
    endtask

    task automatic t_global();
        logic [31:0] v;
        wr(2'd0, 32'h8000_0000);
        rd(2'd0, v); chk("R2 global enable set", v, 32'h8000_0000);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R2 R8 global word low bits zero", v, 32'h8000_0000);
        wr(2'd0, 32'h7FFF_FFFF);
        rd(2'd0, v); chk("R2 global enable cleared", v, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        pulse(4'b0001);
        rd(2'd1, v); chk("R4 R7 write-half-full edge sets bit0", v, 32'h1);
        pulse(4'b1000);
        rd(2'd1, v); chk("R4 R7 read-full edge sets bit3", v, 32'h9);
        wr(2'd1, 32'h9);
        rd(2'd1, v); chk("R5 flip clears bits 3 and 0", v, 32'h0);
    endtask

    task automatic t_toggle();
        logic [31:0] v;
        wr(2'd1, 32'h5);
        rd(2'd1, v); chk("R5 flip raises bits from 0", v, 32'h5);
        wr(2'd1, 32'h0);
        rd(2'd1, v); chk("R5 zero write leaves status", v, 32'h5);
        wr(2'd1, 32'h6);
        rd(2'd1, v); chk("R5 mixed flip", v, 32'h3);
        wr(2'd1, 32'h3);
        rd(2'd1, v); chk("R5 flip back to zero", v, 32'h0);
        wr(2'd1, 32'hFFFF_FFF0);
        rd(2'd1, v); chk("R8 status upper bits ignored", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        @(negedge clk); evt_in[2] = 1'b1;
        rd(2'd1, v); chk("R4 write-empty level sets bit2", v, 32'h4);
        wr(2'd1, 32'h4);
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R4 held level does not set again", v, 32'h0);
        @(negedge clk); evt_in[2] = 1'b0;
        rd(2'd1, v); chk("R4 falling level sets nothing", v, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(2'd2, 32'hA);
        rd(2'd2, v); chk("R6 enable load", v, 32'hA);
        wr(2'd2, 32'h3);
        rd(2'd2, v); chk("R6 enable replaced not merged", v, 32'h3);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R8 enable upper bits zero", v, 32'hF);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_irq();
        wr(2'd1, 32'h2);
        wr(2'd2, 32'h2);
        repeat (2) @(negedge clk);
        chk("R3 global off keeps irq low", {31'h0, irq}, 32'h0);
        wr(2'd0, 32'h8000_0000);
        chk("R9 irq not yet raised", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq raised one cycle later", {31'h0, irq}, 32'h1);
        wr(2'd2, 32'h1);
        @(negedge clk);
        chk("R9 masked source drops irq", {31'h0, irq}, 32'h0);
        wr(2'd2, 32'h2);
        @(negedge clk);
        chk("R9 irq back on", {31'h0, irq}, 32'h1);
        wr(2'd0, 32'h0);
        @(negedge clk);
        chk("R3 global disable drops irq", {31'h0, irq}, 32'h0);
        wr(2'd1, 32'h2);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        wr(2'd1, 32'h2);
        @(negedge clk);
        evt_in[1] = 1'b1;
        wr_en = 1'b1; reg_addr = 2'd1; wr_data = 32'h2;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        rd(2'd1, v); chk("R10 edge beats flip on same bit", v, 32'h2);
        evt_in[1] = 1'b0;
        wr(2'd1, 32'h2);
        rd(2'd1, v); chk("R10 cleanup", v, 32'h0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        rd(2'd3, v); chk("R8 offset 3 reads zero", v, 32'h0);
        wr(2'd2, 32'h5);
        rd(2'd2, v); chk("R11 read enable", v, 32'h5);
        wr(2'd2, 32'hC);
        repeat (3) @(negedge clk);
        chk("R11 rd_data holds without strobe", rd_data, 32'h5);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = 2'd2; wr_en = 1'b1; wr_data = 32'h9;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R11 read returns value before same-edge write", rd_data, 32'hC);
        rd(2'd2, v); chk("R11 later read sees write", v, 32'h9);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; reg_addr = '0; wr_data = '0; evt_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_global();
        t_layout();
        t_toggle();
        t_level();
        t_enable();
        t_irq();
        t_set_wins();
        t_read();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule